// File: doc/BRIEF.md
# Shared Free-Running Counter with Per-Core Compare Timers

This block keeps one free-running counter that every core in a cluster can see. The counter's width is set at build time to 32 bits plus a multiple of four bits, with 64 bits at most. Software reads the counter as two 32-bit words. The counter never stops, so a reader can take the high word, then the low word, then the high word again. If the two high samples differ, the reader repeats the sequence, because a carry crossed between the words.

Each core owns a 64-bit compare value, written as two 32-bit halves. When the counter reaches a core's compare value, that core's timer-pending flag is raised. The flag drives one output line per core and can also be read through a per-core status word. Software writes the high half first and the low half second. The high write disarms the comparison and the low write arms it, so a compare value that has only been half written can never fire. A write to either half also clears that core's pending flag.

A read-only configuration word reports the core count and the size field of the counter. Software can work out the counter width from that field.

Top module: `gtmr_top`

## Requirements
- R1: After reset the counter holds 0. It then rises by exactly one on every clock edge and wraps to 0 after 2^W - 1, where W = 32 + 4*COUNT_NIBBLES.
- R2: Word address 1 reads counter bits 31:0 and word address 2 reads counter bits 63:32. A read strobed at an edge returns, just after that edge, the counter value that was present before that edge.
- R3: Word address 0 is read-only. It returns COUNT_NIBBLES in bits 3:0 and NUM_CORES-1 in bits 11:8, with all other bits zero, so that the counter width is 32 + 4 times bits 3:0.
- R4: Bits of the high counter word at positions W-32 and above always read as zero.
- R5: Core c has its compare low word at word address 4*(c+1) and its compare high word at 4*(c+1)+1. Both words read back exactly what was last written.
- R6: A core's pending flag is set on the edge where that core's comparison is armed and the counter equals {high, low}. It then stays set until that core's compare is written, and it affects no other core. Reset clears all pending flags.
- R7: Word address 4*(c+1)+2 returns core c's pending flag in bit 0, with the other bits zero. The output timerPend[c] carries the same flag.
- R8: A write to either compare word of core c clears core c's pending flag. If that write falls on the same edge as a match, the clear wins.
- R9: Reset leaves every comparison disarmed. A high-word write disarms the comparison and a low-word write arms it, so no match can fire between the two writes.
- R10: Word offset 3 of any block and every address above 4*NUM_CORES+2 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Write strobe for one cycle |
| regRdEn | input | 1 | Read strobe for one cycle |
| regAddr | input | ADDR_W | Word address (ADDR_W = clog2(4*(NUM_CORES+1))) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered and valid after the strobed edge |
| timerPend | output | NUM_CORES | Per-core timer-pending flags |

## Verification
Two events can land on the same clock edge: a compare-word write from software and a hardware match on that same core. The bench provokes this by arming a core with a known target, waiting until the cycle before the counter reaches that target, and then issuing a low-word write so that the write edge is the match edge. The result is judged correct if the pending flag stays low after that edge and then rises exactly at the new target. A second overlap is a counter read that races a low-word carry. This is covered by high-low-high read sequences, whose values are checked against a cycle count kept by the bench itself.

// File: rtl/gtmr_pkg.sv
`timescale 1ns/1ps
package gtmr_pkg;
  localparam int CORE_IDX_W = 8;
  localparam int DATA_W     = 32;

  // word offsets within a per-core block and in the global block
  localparam int OFS_CMP_LO = 0;
  localparam int OFS_CMP_HI = 1;
  localparam int OFS_PEND   = 2;
  localparam int WD_CFG     = 0;
  localparam int WD_CNT_LO  = 1;
  localparam int WD_CNT_HI  = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_PEND
  } rdSel_e;

  typedef struct packed {
    logic                  cmpLoWr;
    logic                  cmpHiWr;
    logic [CORE_IDX_W-1:0] wrCore;
    logic                  rdEn;
    rdSel_e                rdSel;
    logic [CORE_IDX_W-1:0] rdCore;
  } ctlStrobes_t;
endpackage

// File: rtl/gtmr_ctrl.sv
`timescale 1ns/1ps
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 5
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobes_t       strobes
);
  localparam int BLK_W = ADDR_W - 2;

  logic [BLK_W-1:0] blk;
  logic [1:0]       ofs;
  logic             isGlobal;
  logic             isCore;
  logic [CORE_IDX_W-1:0] coreIdx;

  assign blk      = regAddr[ADDR_W-1:2];
  assign ofs      = regAddr[1:0];
  assign isGlobal = (blk == '0);
  assign isCore   = (blk != '0) && (int'(blk) <= NUM_CORES);
  assign coreIdx  = CORE_IDX_W'(blk - BLK_W'(1));

  always_comb begin
    strobes         = '0;
    strobes.rdEn    = regRdEn;
    strobes.rdSel   = SEL_NONE;
    strobes.rdCore  = coreIdx;
    strobes.wrCore  = coreIdx;
    strobes.cmpLoWr = regWrEn && isCore && (int'(ofs) == OFS_CMP_LO);
    strobes.cmpHiWr = regWrEn && isCore && (int'(ofs) == OFS_CMP_HI);
    if (isGlobal) begin
      case (int'(ofs))
        WD_CFG:    strobes.rdSel = SEL_CFG;
        WD_CNT_LO: strobes.rdSel = SEL_CNT_LO;
        WD_CNT_HI: strobes.rdSel = SEL_CNT_HI;
        default:   strobes.rdSel = SEL_NONE;
      endcase
    end else if (isCore) begin
      case (int'(ofs))
        OFS_CMP_LO: strobes.rdSel = SEL_CMP_LO;
        OFS_CMP_HI: strobes.rdSel = SEL_CMP_HI;
        OFS_PEND:   strobes.rdSel = SEL_PEND;
        default:    strobes.rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gtmr_cmp_unit.sv
`timescale 1ns/1ps
module gtmr_cmp_unit (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] cntWide,
  input  logic        loWr,
  input  logic        hiWr,
  input  logic [31:0] wrData,
  output logic [31:0] cmpLo,
  output logic [31:0] cmpHi,
  output logic        pend
);
  logic armed;
  logic hit;

  assign hit = armed && (cntWide == {cmpHi, cmpLo});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpLo <= '0;
      cmpHi <= '0;
      armed <= 1'b0;
    end else if (hiWr) begin
      cmpHi <= wrData;
      armed <= 1'b0;
    end else if (loWr) begin
      cmpLo <= wrData;
      armed <= 1'b1;
    end
  end

  // a compare write outranks a match on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pend <= 1'b0;
    else if (loWr || hiWr)  pend <= 1'b0;
    else if (hit)           pend <= 1'b1;
  end
endmodule

// File: rtl/gtmr_dpath.sv
`timescale 1ns/1ps
module gtmr_dpath
  import gtmr_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int COUNT_NIBBLES = 4,
  localparam int CNT_W        = 32 + 4 * COUNT_NIBBLES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_CORES-1:0] pendOut,
  output logic [CNT_W-1:0]     cntVal
);
  localparam logic [DATA_W-1:0] CFG_WORD =
    (DATA_W'(NUM_CORES - 1) << 8) | DATA_W'(COUNT_NIBBLES);

  logic [CNT_W-1:0]  cnt;
  logic [63:0]       cntWide;
  logic [DATA_W-1:0] cmpLoArr [NUM_CORES];
  logic [DATA_W-1:0] cmpHiArr [NUM_CORES];
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] selLo;
  logic [DATA_W-1:0] selHi;
  logic              selPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + CNT_W'(1);
  end

  assign cntWide = 64'(cnt);
  assign cntVal  = cnt;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic loWr;
    logic hiWr;
    assign loWr = strobes.cmpLoWr && (strobes.wrCore == CORE_IDX_W'(c));
    assign hiWr = strobes.cmpHiWr && (strobes.wrCore == CORE_IDX_W'(c));
    gtmr_cmp_unit u_cmp (
      .clk    (clk),
      .rstN   (rstN),
      .cntWide(cntWide),
      .loWr   (loWr),
      .hiWr   (hiWr),
      .wrData (wrData),
      .cmpLo  (cmpLoArr[c]),
      .cmpHi  (cmpHiArr[c]),
      .pend   (pendOut[c])
    );
  end

  always_comb begin
    selLo   = '0;
    selHi   = '0;
    selPend = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (strobes.rdCore == CORE_IDX_W'(c)) begin
        selLo   = cmpLoArr[c];
        selHi   = cmpHiArr[c];
        selPend = pendOut[c];
      end
    end
    case (strobes.rdSel)
      SEL_CFG:    rdNext = CFG_WORD;
      SEL_CNT_LO: rdNext = cntWide[31:0];
      SEL_CNT_HI: rdNext = cntWide[63:32];
      SEL_CMP_LO: rdNext = selLo;
      SEL_CMP_HI: rdNext = selHi;
      SEL_PEND:   rdNext = {{(DATA_W-1){1'b0}}, selPend};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobes.rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/gtmr_top.sv
`timescale 1ns/1ps
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int COUNT_NIBBLES = 4,
  localparam int ADDR_W       = $clog2(4 * (NUM_CORES + 1)),
  localparam int CNT_W        = 32 + 4 * COUNT_NIBBLES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic [NUM_CORES-1:0] timerPend
);
  ctlStrobes_t      strobes;
  logic [CNT_W-1:0] cntVal;

  gtmr_ctrl #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .regAddr(regAddr),
    .strobes(strobes)
  );

  gtmr_dpath #(.NUM_CORES(NUM_CORES), .COUNT_NIBBLES(COUNT_NIBBLES)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (regWrData),
    .rdData (regRdData),
    .pendOut(timerPend),
    .cntVal (cntVal)
  );
endmodule

// File: rtl/gtmr_checker.sv
`timescale 1ns/1ps
module gtmr_checker #(
  parameter int NUM_CORES     = 4,
  parameter int COUNT_NIBBLES = 4,
  localparam int ADDR_W       = $clog2(4 * (NUM_CORES + 1)),
  localparam int CNT_W        = 32 + 4 * COUNT_NIBBLES
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic                 regRdEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [31:0]          regRdData,
  input logic [NUM_CORES-1:0] timerPend,
  input logic [CNT_W-1:0]     cntVal
);
  function automatic logic isMapped(logic [ADDR_W-1:0] a);
    return (a[1:0] != 2'd3) && (int'(a >> 2) <= NUM_CORES);
  endfunction

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cntVal == $past(cntVal) + CNT_W'(1));

  p_rd_lo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(1)) |=> regRdData == $past(cntVal[31:0]));

  if (CNT_W < 64) begin : g_hi
    localparam logic [31:0] HI_KEEP = 32'((64'd1 << (CNT_W - 32)) - 64'd1);
    p_hi_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
      (regRdEn && regAddr == ADDR_W'(2)) |=> (regRdData & ~HI_KEEP) == '0);
  end

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !isMapped(regAddr)) |=> regRdData == '0);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic wrCmp;
    assign wrCmp = regWrEn && (regAddr == ADDR_W'(4 * (c + 1)) ||
                               regAddr == ADDR_W'(4 * (c + 1) + 1));

    p_wr_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      wrCmp |=> !timerPend[c]);

    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (timerPend[c] && !wrCmp) |=> timerPend[c]);

    p_pend_reg_r7: assert property (@(posedge clk) disable iff (!rstN)
      (regRdEn && regAddr == ADDR_W'(4 * (c + 1) + 2)) |=>
        regRdData == {31'd0, $past(timerPend[c])});
  end
endmodule

bind gtmr_top gtmr_checker #(
  .NUM_CORES    (NUM_CORES),
  .COUNT_NIBBLES(COUNT_NIBBLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .regAddr  (regAddr),
  .regRdData(regRdData),
  .timerPend(timerPend),
  .cntVal   (cntVal)
);

// File: tb/sim_gtmr_top.sv
`timescale 1ns/1ps
module sim_gtmr_top;
  localparam int NC = 4;
  localparam int NB = 4;
  localparam int AW = $clog2(4 * (NC + 1));

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [NC-1:0] timerPend;

  int edgeCnt = 0;
  int nChk = 0;
  int nBad = 0;

  gtmr_top #(.NUM_CORES(NC), .COUNT_NIBBLES(NB)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .timerPend(timerPend)
  );

  always #2.5 clk = ~clk;

  // edge k after reset release sees the counter at k-1 before it
  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  function automatic int aLo(int c);   return 4 * (c + 1);     endfunction
  function automatic int aHi(int c);   return 4 * (c + 1) + 1; endfunction
  function automatic int aPend(int c); return 4 * (c + 1) + 2; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(int a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = AW'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(int a, output logic [31:0] d, output int e);
    regRdEn = 1'b1; regAddr = AW'(a);
    @(negedge clk);
    d = regRdData; e = edgeCnt;
    regRdEn = 1'b0;
  endtask

  task automatic waitEdge(int n);
    while (edgeCnt < n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R6 reset pend", 32'(timerPend), 32'd0);
    chk("R1 reset rd", regRdData, 32'd0);
  endtask

  task automatic t_config;
    logic [31:0] d; int e;
    rdReg(0, d, e);
    chk("R3 config", d, (32'(NC - 1) << 8) | 32'(NB));
  endtask

  task automatic t_counter;
    logic [31:0] d; int e;
    rdReg(1, d, e);
    chk("R1 cnt lo", d, 32'(e - 1));
    rdReg(1, d, e);
    chk("R2 cnt lo next", d, 32'(e - 1));
    rdReg(2, d, e);
    chk("R4 cnt hi", d, 32'd0);
  endtask

  task automatic t_hilohi;
    logic [31:0] h1, lo, h2; int e;
    rdReg(2, h1, e);
    rdReg(1, lo, e);
    rdReg(2, h2, e);
    chk("R2 hi stable", h2, h1);
    chk("R2 lo in seq", lo, 32'(e - 2));
  endtask

  task automatic t_readback;
    logic [31:0] d; int e;
    for (int c = 0; c < NC; c += NC - 1) begin
      wrReg(aHi(c), 32'hC0DE_0000 + 32'(c));
      wrReg(aLo(c), 32'h5A5A_0000 + 32'(c));
      rdReg(aLo(c), d, e);
      chk("R5 cmp lo", d, 32'h5A5A_0000 + 32'(c));
      rdReg(aHi(c), d, e);
      chk("R5 cmp hi", d, 32'hC0DE_0000 + 32'(c));
    end
  endtask

  task automatic t_match;
    logic [31:0] d; int e; int k;
    k = edgeCnt + 40;
    wrReg(aHi(1), 32'd0);
    wrReg(aLo(1), 32'(k));
    waitEdge(k);
    chk("R6 before match", 32'(timerPend[1]), 32'd0);
    @(negedge clk);
    chk("R6 at match", 32'(timerPend), 32'b0010);
    repeat (5) @(negedge clk);
    chk("R6 held", 32'(timerPend[1]), 32'd1);
    rdReg(aPend(1), d, e);
    chk("R7 pend reg set", d, 32'd1);
    rdReg(aPend(0), d, e);
    chk("R7 pend reg clear", d, 32'd0);
  endtask

  task automatic t_clear_and_arm;
    int k;
    wrReg(aHi(1), 32'd0);
    chk("R8 hi write clears", 32'(timerPend[1]), 32'd0);
    k = edgeCnt + 30;
    wrReg(aLo(1), 32'(k));
    wrReg(aHi(1), 32'd0);
    waitEdge(k + 6);
    chk("R9 disarmed by hi", 32'(timerPend[1]), 32'd0);
    k = edgeCnt + 20;
    wrReg(aLo(1), 32'(k));
    waitEdge(k);
    chk("R9 armed pre", 32'(timerPend[1]), 32'd0);
    @(negedge clk);
    chk("R9 armed by lo", 32'(timerPend[1]), 32'd1);
    wrReg(aLo(1), 32'hFFFF_FFF0);
    chk("R8 lo write clears", 32'(timerPend[1]), 32'd0);
  endtask

  task automatic t_collision;
    int k;
    k = edgeCnt + 20;
    wrReg(aHi(2), 32'd0);
    wrReg(aLo(2), 32'(k));
    waitEdge(k);
    wrReg(aLo(2), 32'(k + 10));
    chk("R8 write beats match", 32'(timerPend[2]), 32'd0);
    waitEdge(k + 10);
    chk("R8 new target pre", 32'(timerPend[2]), 32'd0);
    @(negedge clk);
    chk("R8 new target fires", 32'(timerPend[2]), 32'd1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; int e; logic [NC-1:0] pendBefore;
    rdReg(3, d, e);
    chk("R10 global ofs3", d, 32'd0);
    rdReg(aLo(0) + 3, d, e);
    chk("R10 core ofs3", d, 32'd0);
    rdReg(4 * (NC + 1), d, e);
    chk("R10 beyond cores", d, 32'd0);
    pendBefore = timerPend;
    wrReg(3, 32'hDEAD_BEEF);
    wrReg(4 * (NC + 1), 32'hDEAD_BEEF);
    wrReg(aLo(0) + 3, 32'hDEAD_BEEF);
    chk("R10 pend untouched", 32'(timerPend), 32'(pendBefore));
    rdReg(aLo(0), d, e);
    chk("R10 cmp lo untouched", d, 32'h5A5A_0000);
    rdReg(0, d, e);
    chk("R10 config untouched", d, (32'(NC - 1) << 8) | 32'(NB));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", nChk + 1, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_config();
    t_counter();
    t_hilohi();
    t_readback();
    t_match();
    t_clear_and_arm();
    t_collision();
    t_unmapped();
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule